// File: doc/BRIEF.md
# Three-Group Interrupt Register Bank

This block gathers byte-wide interrupt sources into three groups: two groups that feed the normal interrupt line (group A and group B) and one group that feeds the fast interrupt line. Each group shows three registers on an 8-bit read/write bus: a status byte with the current state of its sources, a mask byte that software writes, and a request byte equal to status AND mask. The normal interrupt output is high while either normal group has a nonzero request byte. The fast output is high while the fast group has one.

Most sources are levels that pass straight into status. Three bits of group A are latched instead: flyback, ring and power-on-reset. A one-cycle pulse on the source sets the bit, and it stays set until software clears it by writing ones to the clear register. Bit 7 of group A and bit 7 of the fast group always read as one. Register reads are combinational from the address. Writes take effect at the rising clock edge.

Top module: `irq_bank3`

## Requirements
- R1: Register map (7-bit byte address): group A status/request/mask at 0x10/0x14/0x18, group B at 0x20/0x24/0x28, fast group at 0x30/0x34/0x38. A read from any other address returns 0x00.
- R2: Reading a group's request register (base+4) returns that group's status AND its mask.
- R3: The mask registers at 0x18, 0x28 and 0x38 read back the last byte written to them. They are 0x00 after reset.
- R4: Status bit 7 of group A and status bit 7 of the fast group always read as 1.
- R5: Group B status bits 0 to 7 follow src_b bits 0 to 7 directly (fast expansion, sound pointer, serial, disc interface, floppy, normal expansion, keyboard tx empty, keyboard rx full).
- R6: Fast-group status bits 0 (floppy data), 4 (serial) and 6 (fast expansion) follow src_f. Bits 1, 2, 3 and 5 always read 0.
- R7: Group A bits 0, 1, 5 and 6 follow src_a as levels. Bits 2 (flyback), 3 (ring) and 4 (power-on-reset) are set by src_a being high at a clock edge, and they stay set after the source falls.
- R8: Writing to 0x14 clears each latched group A bit (2, 3, 4) whose write-data bit is 1. Latched bits with a 0 in the write data are unchanged.
- R9: If a latched bit's source is high in the same cycle as a clear of that bit, the bit stays set.
- R10: After reset, group A status bit 4 (power-on-reset) is set and bits 2 and 3 are clear.
- R11: irq is 1 exactly when the group A or group B request byte is nonzero. fiq is 1 exactly when the fast-group request byte is nonzero.
- R12: Writes to undefined addresses and to status or request registers other than 0x14 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_a | input | 8 | Group A sources (levels, or event pulses on bits 2 to 4) |
| src_b | input | 8 | Group B level sources |
| src_f | input | 8 | Fast-group level sources |
| irq | output | 1 | Combined normal interrupt |
| fiq | output | 1 | Fast interrupt |

## Verification
A table of source and mask patterns exercises the request logic. It contains sources without masks, masks without sources, partial overlap, unused fast bits that are driven high, and the forced bit 7 that is unmasked. Together these separate an AND from an OR, a correct decode of unused bits from a pass-through, and a correct forced bit from a missing one. Directed sequences pulse each latched source and clear with wrong and right data bits. They also collide a set with a clear in the same cycle, which separates set-priority from clear-priority. Writes to holes and to read-only registers are followed by readback of every mask and status register.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;

  // register kind within a group: addr[3:2]
  typedef enum logic [1:0] {REG_STATUS = 2'd0, REG_REQUEST = 2'd1, REG_MASK = 2'd2, REG_NONE = 2'd3} reg_kind_t;

  localparam int NGROUPS = 3;
  localparam logic [DATA_W-1:0] A_LATCH = 8'h1C;
  localparam logic [DATA_W-1:0] A_FORCE = 8'h80;
  localparam logic [DATA_W-1:0] A_USED  = 8'hFF;
  localparam logic [DATA_W-1:0] A_POR   = 8'h10;
  localparam logic [DATA_W-1:0] F_FORCE = 8'h80;
  localparam logic [DATA_W-1:0] F_USED  = 8'hD1;

  function automatic logic [DATA_W-1:0] masked_req(input logic [DATA_W-1:0] st, input logic [DATA_W-1:0] mk);
    return st & mk;
  endfunction

  function automatic logic [DATA_W-1:0] status_of(input logic [DATA_W-1:0] lvl, input logic [DATA_W-1:0] held,
                                                  input logic [DATA_W-1:0] latch_bits, input logic [DATA_W-1:0] force_bits,
                                                  input logic [DATA_W-1:0] used_bits);
    return force_bits | (held & latch_bits) | (lvl & used_bits & ~latch_bits & ~force_bits);
  endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_bank_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]      addr,
  input  logic               wr,
  output logic               hit,
  output logic [1:0]         grp,
  output reg_kind_t          kind,
  output logic [NGROUPS-1:0] mask_we,
  output logic               clr_we
);
  logic [1:0] grp_field;
  logic       upper_zero;

  assign grp_field  = addr[5:4];
  assign upper_zero = (addr[AW-1:6] == '0);

  always_comb begin
    hit  = upper_zero && (addr[1:0] == 2'b00) && (grp_field != 2'd0) && (addr[3:2] != 2'd3);
    grp  = grp_field - 2'd1;
    kind = hit ? reg_kind_t'(addr[3:2]) : REG_NONE;
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_mwe
    assign mask_we[g] = wr && hit && (kind == REG_MASK) && (grp == 2'(g));
  end

  assign clr_we = wr && hit && (kind == REG_REQUEST) && (grp == 2'd0);
endmodule

// File: rtl/irq_group.sv
module irq_group
  import irq_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] LATCH_BITS  = '0,
  parameter logic [DATA_W-1:0] FORCE_BITS  = '0,
  parameter logic [DATA_W-1:0] USED_BITS   = '1,
  parameter logic [DATA_W-1:0] RESET_LATCH = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wd,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] req,
  output logic              any_req
);
  logic [DATA_W-1:0] latch_q, mask_q;
  logic [DATA_W-1:0] clr_vec, set_vec;

  assign clr_vec = clr_we ? (clr_data & LATCH_BITS) : '0;
  assign set_vec = src & LATCH_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= RESET_LATCH & LATCH_BITS;
      mask_q  <= '0;
    end else begin
      latch_q <= (latch_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  assign status  = status_of(src, latch_q, LATCH_BITS, FORCE_BITS, USED_BITS);
  assign mask    = mask_q;
  assign req     = masked_req(status, mask_q);
  assign any_req = |req;

  // R3: mask only changes on its own write strobe
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  // R9: an event seen at an edge is held afterwards, whatever the clear did
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(set_vec)) == $past(set_vec)));

  // R8: a clear with no coincident event empties the chosen latches
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((latch_q & $past(clr_data & ~src & LATCH_BITS)) == '0));
endmodule

// File: rtl/irq_bank3.sv
module irq_bank3
  import irq_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_f,
  output logic              irq,
  output logic              fiq
);
  logic              hit, clr_we;
  logic [1:0]        grp;
  reg_kind_t         kind;
  logic [NGROUPS-1:0] mask_we, any_req;
  logic [DATA_W-1:0] st   [NGROUPS];
  logic [DATA_W-1:0] mk   [NGROUPS];
  logic [DATA_W-1:0] rq   [NGROUPS];
  logic [DATA_W-1:0] srcs [NGROUPS];

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;
  assign srcs[2] = src_f;

  irq_bus_decode #(.AW(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .hit(hit), .grp(grp), .kind(kind),
    .mask_we(mask_we), .clr_we(clr_we)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam logic [DATA_W-1:0] LB = (g == 0) ? A_LATCH : '0;
    localparam logic [DATA_W-1:0] FB = (g == 0) ? A_FORCE : (g == 2) ? F_FORCE : '0;
    localparam logic [DATA_W-1:0] UB = (g == 2) ? F_USED : '1;
    localparam logic [DATA_W-1:0] RB = (g == 0) ? A_POR : '0;
    irq_group #(.LATCH_BITS(LB), .FORCE_BITS(FB), .USED_BITS(UB), .RESET_LATCH(RB)) u_grp (
      .clk(clk), .rst_n(rst_n), .src(srcs[g]),
      .clr_we((g == 0) ? clr_we : 1'b0), .clr_data(bus_wdata),
      .mask_we(mask_we[g]), .mask_wd(bus_wdata),
      .status(st[g]), .mask(mk[g]), .req(rq[g]), .any_req(any_req[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (kind)
        REG_STATUS:  bus_rdata = st[grp];
        REG_REQUEST: bus_rdata = rq[grp];
        REG_MASK:    bus_rdata = mk[grp];
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign irq = any_req[0] | any_req[1];
  assign fiq = any_req[2];

  // R12: a write that misses every mask register leaves all masks alone
  a_r12_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (mask_we == '0)) |=> ($stable(mk[0]) && $stable(mk[1]) && $stable(mk[2])));

  // R1: decode never selects more than one mask register
  a_r1_one_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we));
endmodule

// File: tb/irq_bank3_test.sv
module irq_bank3_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] src_a = '0, src_b = '0, src_f = '0;
  logic       irq, fiq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_bank3 uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_a(src_a), .src_b(src_b),
    .src_f(src_f), .irq(irq), .fiq(fiq));

  // stimulus: b, f, mask_b, mask_f, expected irq, expected fiq
  typedef struct packed {logic [7:0] b, f, mb, mf; logic ei, ef;} vec_t;
  localparam vec_t VECS [5] = '{
    '{8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0},
    '{8'h0F, 8'h00, 8'hF0, 8'h01, 1'b0, 1'b0},
    '{8'h21, 8'h10, 8'h01, 8'h10, 1'b1, 1'b1},
    '{8'h00, 8'h0E, 8'hFF, 8'h0E, 1'b0, 1'b0},
    '{8'h80, 8'h00, 8'h80, 8'h80, 1'b1, 1'b1}
  };

  function automatic logic [7:0] exp_fstat(input logic [7:0] f);
    return {1'b1, f[6], 1'b0, f[4], 3'b000, f[0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_check("R3", 7'h18, 8'h00);
    rd_check("R3", 7'h28, 8'h00);
    rd_check("R3", 7'h38, 8'h00);
    rd_check("R10", 7'h10, 8'h90);
    rd_check("R6", 7'h30, 8'h80);
    check("R11", {7'b0, irq}, 8'h00);
    check("R11", {7'b0, fiq}, 8'h00);

    // table walk
    foreach (VECS[i]) begin
      src_b = VECS[i].b; src_f = VECS[i].f;
      wr(7'h28, VECS[i].mb);
      wr(7'h38, VECS[i].mf);
      rd_check("R5", 7'h20, VECS[i].b);
      rd_check("R6", 7'h30, exp_fstat(VECS[i].f));
      rd_check("R2", 7'h24, VECS[i].b & VECS[i].mb);
      rd_check("R2", 7'h34, exp_fstat(VECS[i].f) & VECS[i].mf);
      rd_check("R3", 7'h28, VECS[i].mb);
      rd_check("R3", 7'h38, VECS[i].mf);
      check("R11", {7'b0, irq}, {7'b0, VECS[i].ei});
      check("R11", {7'b0, fiq}, {7'b0, VECS[i].ef});
    end
    wr(7'h28, 8'h00); wr(7'h38, 8'h00);
    src_b = '0; src_f = '0;

    // group A levels and power-on-reset clear
    src_a = 8'h63;
    rd_check("R7", 7'h10, 8'hF3);
    wr(7'h14, 8'h10);
    rd_check("R8", 7'h10, 8'hE3);
    src_a = 8'h00;
    rd_check("R4", 7'h10, 8'h80);

    // latched event, wrong-bit clear, right-bit clear
    @(negedge clk); src_a = 8'h04;
    @(negedge clk); src_a = 8'h00;
    rd_check("R7", 7'h10, 8'h84);
    wr(7'h14, 8'h08);
    rd_check("R8", 7'h10, 8'h84);
    wr(7'h14, 8'h04);
    rd_check("R8", 7'h10, 8'h80);

    // set and clear in the same cycle
    @(negedge clk); src_a = 8'h08; bus_addr = 7'h14; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk); src_a = 8'h00; bus_wr = 1'b0;
    rd_check("R9", 7'h10, 8'h88);
    wr(7'h14, 8'h1C);
    rd_check("R8", 7'h10, 8'h80);

    // forced bit unmasked in group A drives irq
    wr(7'h18, 8'h80);
    rd_check("R2", 7'h14, 8'h80);
    check("R11", {7'b0, irq}, 8'h01);
    check("R11", {7'b0, fiq}, 8'h00);

    // stray writes
    wr(7'h1C, 8'hFF); wr(7'h10, 8'hFF); wr(7'h24, 8'hFF); wr(7'h3C, 8'hFF);
    wr(7'h58, 8'hFF); wr(7'h19, 8'hFF);
    rd_check("R12", 7'h18, 8'h80);
    rd_check("R12", 7'h28, 8'h00);
    rd_check("R12", 7'h38, 8'h00);
    rd_check("R12", 7'h10, 8'h80);
    rd_check("R1", 7'h1C, 8'h00);
    rd_check("R1", 7'h00, 8'h00);
    rd_check("R1", 7'h7C, 8'h00);
    rd_check("R1", 7'h19, 8'h00);
    wr(7'h18, 8'h00);
    check("R11", {7'b0, irq}, 8'h00);

    // reset again restores power-on-reset flag and masks
    wr(7'h38, 8'hA5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check("R10", 7'h10, 8'h90);
    rd_check("R3", 7'h38, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_tests++; n_fail++; $display("FAIL watchdog: got timeout expected finish"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule